// File: doc/BRIEF.md
# Extended Address Register with Return Stack

This block supplies the upper program-address bits that sit above a 16-bit CPU program counter, which lets code run across a linear space eight times larger than the counter alone can reach. A small register holds those upper bits. At the start of each bus cycle the register reloads from one of three sources. The first is an adjust path that adds one, subtracts one or passes the value through, as a boundary detector elsewhere requests. The second is a holding register filled by an instruction translator, used when a far jump or far call completes. The third is the top of a private last-in-first-out stack, used when a return completes.

The stack saves the register when a far call has fetched its operand bytes and when an interrupt vectors. A return later restores the saved value. The register value is always the adjusted value, so the pushed value and the address bits driven to memory are both post-adjust. Opcode decoding and boundary detection happen outside this block and arrive as single-cycle strobes. Overflow and underflow of the stack are reported as one-cycle error pulses. Neither error corrupts the stack or the register.

Top module: `xaddr_unit`

## Requirements
- R1: During and straight after synchronous reset, `addr_hi` is 0, `stk_empty` is 1, and `stk_full`, `stk_ovf` and `stk_unf` are 0.
- R2: In a cycle with `cyc_start` low, `addr_hi` keeps its value whatever the load and adjust inputs do, and `ret_end` pops nothing.
- R3: When `cyc_start` is high and no load or return event is present, `addr_hi` becomes its value plus one modulo 2^XW if only `inc_req` is high. It becomes its value minus one modulo 2^XW if only `dec_req` is high. It stays unchanged if both are high or both are low.
- R4: When `cyc_start` is high together with `fjmp_end` or `fcall_end`, and `ret_end` is low, `addr_hi` loads `hold_val`, and any adjust request is ignored.
- R5: When `cyc_start` and `ret_end` are high and the stack is not empty, the top entry is removed and loaded into `addr_hi`. This takes priority over the holding register and the adjust path.
- R6: A high `call_push` or `int_push` pushes the value `addr_hi` shows in that cycle, before any reload at the same edge. Entries come back in reverse order of pushing.
- R7: The stack holds DEPTH entries of XW bits. `stk_full` is high exactly when it holds DEPTH entries, and `stk_empty` is high exactly when it holds none.
- R8: A push request while the stack is full leaves the stack contents and count unchanged. It raises `stk_ovf` for the single following cycle.
- R9: A return (`cyc_start` and `ret_end`) while the stack is empty leaves `addr_hi` unchanged, even with an adjust or hold request present. It raises `stk_unf` for the single following cycle.
- R10: A push request in the same cycle as a return (`cyc_start` and `ret_end`) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Strobe marking the start of a bus cycle; reloads are taken only here |
| inc_req | input | 1 | Request to add one to the register at this cycle start |
| dec_req | input | 1 | Request to subtract one from the register at this cycle start |
| fjmp_end | input | 1 | Far jump completes; load the holding value |
| fcall_end | input | 1 | Far call completes; load the holding value |
| hold_val | input | XW | Holding register value from the translator |
| call_push | input | 1 | Far call operands read; save the register |
| int_push | input | 1 | Interrupt vectoring; save the register |
| ret_end | input | 1 | Return completes; restore the register from the stack |
| addr_hi | output | XW | Upper memory address bits |
| stk_full | output | 1 | Stack holds DEPTH entries |
| stk_empty | output | 1 | Stack holds no entry |
| stk_ovf | output | 1 | One-cycle pulse after a push on a full stack |
| stk_unf | output | 1 | One-cycle pulse after a return on an empty stack |

## Verification
The assertions check the following on every cycle: the register holds outside cycle starts, it holds on idle cycle starts, a hold load overrides an adjust, the error pulses follow overflow and underflow, the full and empty flags are mutually exclusive, and push and pop never reach the stack together. Only the bench scenarios can show the last-in-first-out order of restored values, the modulo wrap of the adjust path in both directions, and the fact that the value pushed is the one shown before a same-edge reload. The same holds for a full fill to capacity followed by a complete drain, checked against a reference model.

// File: rtl/xaddr_pkg.sv
package xaddr_pkg;
  typedef enum logic [1:0] {
    SRC_KEEP  = 2'd0,
    SRC_ADJ   = 2'd1,
    SRC_HOLD  = 2'd2,
    SRC_STACK = 2'd3
  } xsrc_e;
endpackage

// File: rtl/xaddr_adjust.sv
module xaddr_adjust #(
  parameter int XW = 3
) (
  input  logic [XW-1:0] cur,
  input  logic          inc,
  input  logic          dec,
  output logic [XW-1:0] nxt
);
  localparam logic [XW-1:0] ONE = XW'(1);

  always_comb begin
    unique case ({inc, dec})
      2'b10:   nxt = cur + ONE;
      2'b01:   nxt = cur - ONE;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/xaddr_select.sv
module xaddr_select
  import xaddr_pkg::*;
(
  input  logic  cyc_start,
  input  logic  ret_end,
  input  logic  load_hold,
  input  logic  stk_empty,
  output xsrc_e src
);
  always_comb begin
    if (!cyc_start)    src = SRC_KEEP;
    else if (ret_end)  src = stk_empty ? SRC_KEEP : SRC_STACK;
    else if (load_hold) src = SRC_HOLD;
    else               src = SRC_ADJ;
  end
endmodule

// File: rtl/xaddr_stack.sv
module xaddr_stack #(
  parameter int W     = 3,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [AW-1:0] wr_idx;
  logic [AW-1:0] rd_idx;
  logic          push_ok;
  logic          pop_ok;

  assign full    = (cnt == CMAX);
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign wr_idx  = AW'(cnt);
  assign rd_idx  = AW'(cnt - CW'(1));
  assign top     = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (push_ok) cnt <= cnt + CW'(1);
    else if (pop_ok)  cnt <= cnt - CW'(1);
  end

  // R7: flags never both set
  a_r7_flags_excl: assert property (@(posedge clk) disable iff (rst) !(full && empty));
  // R10: the top never presents push and pop together
  a_r10_no_dual: assert property (@(posedge clk) disable iff (rst) !(push && pop));
  // R6: an accepted push leaves the stack non-empty
  a_r6_push_fills: assert property (@(posedge clk) disable iff (rst)
    push && !full |=> !empty);
endmodule

// File: rtl/xaddr_unit.sv
module xaddr_unit
  import xaddr_pkg::*;
#(
  parameter int XW    = 3,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_start,
  input  logic          inc_req,
  input  logic          dec_req,
  input  logic          fjmp_end,
  input  logic          fcall_end,
  input  logic [XW-1:0] hold_val,
  input  logic          call_push,
  input  logic          int_push,
  input  logic          ret_end,
  output logic [XW-1:0] addr_hi,
  output logic          stk_full,
  output logic          stk_empty,
  output logic          stk_ovf,
  output logic          stk_unf
);
  logic [XW-1:0] xar_q;
  logic [XW-1:0] adj_val;
  logic [XW-1:0] top_val;
  logic          pop_evt;
  logic          push_evt;
  xsrc_e         src;

  assign pop_evt  = cyc_start && ret_end;
  assign push_evt = (call_push || int_push) && !pop_evt;

  xaddr_adjust #(.XW(XW)) u_adj (
    .cur (xar_q),
    .inc (inc_req),
    .dec (dec_req),
    .nxt (adj_val)
  );

  xaddr_select u_sel (
    .cyc_start (cyc_start),
    .ret_end   (ret_end),
    .load_hold (fjmp_end || fcall_end),
    .stk_empty (stk_empty),
    .src       (src)
  );

  xaddr_stack #(.W(XW), .DEPTH(DEPTH)) u_stk (
    .clk   (clk),
    .rst   (rst),
    .push  (push_evt),
    .pop   (pop_evt),
    .wdata (xar_q),
    .top   (top_val),
    .full  (stk_full),
    .empty (stk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xar_q <= '0;
    end else begin
      unique case (src)
        SRC_ADJ:   xar_q <= adj_val;
        SRC_HOLD:  xar_q <= hold_val;
        SRC_STACK: xar_q <= top_val;
        default:   xar_q <= xar_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stk_ovf <= 1'b0;
      stk_unf <= 1'b0;
    end else begin
      stk_ovf <= push_evt && stk_full;
      stk_unf <= pop_evt && stk_empty;
    end
  end

  assign addr_hi = xar_q;

  // R2: no reload outside a bus-cycle start
  a_r2_hold_between: assert property (@(posedge clk) disable iff (rst)
    !cyc_start |=> $stable(addr_hi));
  // R3: idle cycle start keeps value
  a_r3_idle_keep: assert property (@(posedge clk) disable iff (rst)
    cyc_start && !ret_end && !fjmp_end && !fcall_end && (inc_req == dec_req) |=> $stable(addr_hi));
  // R4: hold load wins over adjust
  a_r4_hold_load: assert property (@(posedge clk) disable iff (rst)
    cyc_start && !ret_end && (fjmp_end || fcall_end) |=> addr_hi == $past(hold_val));
  // R8: push on full flagged, fill level kept
  a_r8_ovf_flag: assert property (@(posedge clk) disable iff (rst)
    (call_push || int_push) && !(cyc_start && ret_end) && stk_full |=> stk_ovf && stk_full);
  // R9: return on empty flagged, register kept
  a_r9_unf_flag: assert property (@(posedge clk) disable iff (rst)
    cyc_start && ret_end && stk_empty |=> stk_unf && $stable(addr_hi));
endmodule

// File: tb/xaddr_unit_bench.sv
module xaddr_unit_bench;
  localparam int XW = 3;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 0, inc_req = 0, dec_req = 0, fjmp_end = 0, fcall_end = 0;
  logic call_push = 0, int_push = 0, ret_end = 0;
  logic [XW-1:0] hold_val = '0;
  logic [XW-1:0] addr_hi;
  logic stk_full, stk_empty, stk_ovf, stk_unf;

  always #2 clk = ~clk;

  xaddr_unit #(.XW(XW), .DEPTH(DEPTH)) u_xaddr_unit (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .inc_req(inc_req), .dec_req(dec_req),
    .fjmp_end(fjmp_end), .fcall_end(fcall_end), .hold_val(hold_val),
    .call_push(call_push), .int_push(int_push), .ret_end(ret_end),
    .addr_hi(addr_hi), .stk_full(stk_full), .stk_empty(stk_empty),
    .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [XW+3:0] exp_q [$];
  string         tag_q [$];

  logic [XW-1:0] m_addr = '0;
  logic [XW-1:0] m_stk [DEPTH];
  int            m_cnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [XW+3:0] act, input logic [XW+3:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [XW+3:0] e;
      logic [XW+3:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {addr_hi, stk_full, stk_empty, stk_ovf, stk_unf};
      chk(a === e, t, a, e);
    end
  end

  task automatic step(input bit cs, input bit inc, input bit dec, input bit fj, input bit fc,
                      input logic [XW-1:0] hv, input bit cp, input bit ip, input bit rt,
                      input string tag);
    bit pop_evt, push_evt, ovf, unf;
    logic [XW-1:0] old, top;
    @(negedge clk);
    cyc_start = cs; inc_req = inc; dec_req = dec; fjmp_end = fj; fcall_end = fc;
    hold_val = hv; call_push = cp; int_push = ip; ret_end = rt;
    @(posedge clk);
    old = m_addr;
    pop_evt = cs && rt;
    push_evt = (cp || ip) && !pop_evt;
    ovf = push_evt && (m_cnt == DEPTH);
    unf = pop_evt && (m_cnt == 0);
    top = '0;
    if (pop_evt && m_cnt > 0) begin
      m_cnt--;
      top = m_stk[m_cnt];
    end
    if (cs) begin
      if (pop_evt) m_addr = unf ? old : top;
      else if (fj || fc) m_addr = hv;
      else if (inc && !dec) m_addr = old + 1'b1;
      else if (dec && !inc) m_addr = old - 1'b1;
    end
    if (push_evt && m_cnt < DEPTH) begin
      m_stk[m_cnt] = old;
      m_cnt++;
    end
    exp_q.push_back({m_addr, m_cnt == DEPTH, m_cnt == 0, ovf, unf});
    tag_q.push_back(tag);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    chk({addr_hi, stk_full, stk_empty, stk_ovf, stk_unf} === {3'd0, 4'b0100}, "R1 reset",
        {addr_hi, stk_full, stk_empty, stk_ovf, stk_unf}, {3'd0, 4'b0100});
    rst = 1'b0;
    step(0,0,0,0,0,0,0,0,0, "R1 after reset");
    // R3: increment wraps modulo 8
    for (int i = 0; i < 9; i++) step(1,1,0,0,0,0,0,0,0, "R3 inc wrap");
    // R3: decrement past zero
    step(1,0,1,0,0,0,0,0,0, "R3 dec");
    step(1,0,1,0,0,0,0,0,0, "R3 dec to 7");
    step(1,0,1,0,0,0,0,0,0, "R3 dec wrap");
    step(1,1,1,0,0,0,0,0,0, "R3 both keep");
    step(1,0,0,0,0,0,0,0,0, "R3 none keep");
    // R2: no cycle start ignores everything
    step(0,1,0,0,0,0,0,0,0, "R2 inc ignored");
    step(0,0,0,1,0,3'd5,0,0,0, "R2 fjmp ignored");
    step(0,0,0,0,0,0,0,0,1, "R2 ret ignored");
    // R4: hold load beats adjust
    step(1,1,0,1,0,3'd5,0,0,0, "R4 fjmp load");
    // R6: push current value while call completes
    step(1,0,0,0,1,3'd2,1,0,0, "R6 call push and R4 fcall load");
    step(1,1,0,0,0,0,0,1,0, "R6 int push with inc");
    // R5: restore in reverse order; pop beats hold
    step(1,0,0,0,0,0,0,0,1, "R5 ret restore");
    step(1,1,0,1,0,3'd6,0,0,1, "R5 ret priority");
    // R9: return on empty
    step(1,1,0,1,0,3'd1,0,0,1, "R9 underflow");
    step(0,0,0,0,0,0,0,0,0, "R9 pulse clears");
    // R10: push ignored during a return
    step(1,0,0,1,0,3'd4,1,0,0, "R10 setup push");
    step(1,0,0,0,0,0,1,1,1, "R10 push dropped");
    step(1,0,0,0,0,0,0,0,1, "R10 stack was empty");
    // R7/R8: fill to capacity
    for (int i = 0; i < DEPTH; i++)
      step(1,0,0,1,0,3'(i * 3 + 1),1,0,0, "R7 fill");
    step(0,0,0,0,0,0,1,0,0, "R8 overflow");
    step(0,0,0,0,0,0,0,1,0, "R8 overflow int");
    step(0,0,0,0,0,0,0,0,0, "R8 pulse clears");
    // R6/R7: drain in LIFO order
    for (int i = 0; i < DEPTH; i++) step(1,0,0,0,0,0,0,0,1, "R6 drain LIFO");
    step(1,0,0,0,0,0,0,0,1, "R9 drained underflow");
    step(0,0,0,0,0,0,0,0,0, "R7 idle");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule